// File: doc/BRIEF.md
# Core power mode controller

This block sets the power state of a processor core domain. While the core runs, the block sits in Active. Software arms the Idle request, the wait enable and, if it wants, the clock-off request in a small control/status register. The core then issues a WAIT strobe. The block moves to Idle, halts the core and, when asked, gates the high-frequency clock.

Three wake sources feed a sticky wake latch:
- a maskable event, taken as a level;
- a non-maskable interrupt, taken on its rising edge;
- a debug interrupt, taken on its rising edge.

The latch holds until the core runs an interrupt-acknowledge cycle or until reset. When the latch is set in Idle, the block clears the clock-off request and enters a clock-restart state. It stays there until a stable-clock detector reports the clock as ready. It then returns to Active, clears the Idle request and pulses a resume strobe, so the core enters the interrupt routine of the waking source.

The Power Off mode is left only by restoring supply and applying reset. To this block, that is simply its reset.

Top module: `core_pwr_ctrl`

## Requirements
- R1: While `rst_ni` is low and right after it rises, `mode_o` is Active (2'b00), `csr_rdata_o[2:0]` is 0, `wake_o` and `resume_o` are 0, `core_halt_o` is 0 and `hf_clk_en_o` is 1.
- R2: The register write updates the control bits: bit 0 is the Idle request, bit 1 is clock-off and bit 2 is wait enable. Reads return those bits. Read bit 3 mirrors `clk_rdy_i` and cannot be written.
- R3: In Active, a `wait_i` cycle with bits 0 and 2 both set gives `mode_o` Idle (2'b01) and `core_halt_o` 1 from the next cycle.
- R4: In Active, `wait_i` with bit 0 or bit 2 clear leaves the block in Active.
- R5: `hf_clk_en_o` is 0 only when the block is out of Active and clock-off is set. Setting clock-off while Active leaves the clock running.
- R6: The wake sources map to `wake_src_o` as follows: bit 0 is the maskable level `mask_evt_i`, bit 1 is a rising edge of `nmi_i`, and bit 2 is a rising edge of `dbg_irq_i`. A line held high is not detected again after an acknowledge unless it is the maskable level.
- R7: A latched wake source stays set until a cycle with `intack_i` high, which clears it.
- R8: In Idle with the wake latch set, the next cycle shows `mode_o` as clock-restart (2'b10), with clock-off cleared and `hf_clk_en_o` 1. The block stays in clock-restart while `clk_rdy_i` is low.
- R9: From clock-restart with `clk_rdy_i` high, the next cycle shows Active, with the Idle request cleared and `resume_o` high for exactly one cycle.
- R10: A wake event in Active is latched but does not change the mode. A WAIT issued with the latch already set passes through Idle for one cycle and then goes to clock-restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_we_i | input | 1 | Register write strobe |
| csr_wdata_i | input | 4 | Register write data |
| csr_rdata_o | output | 4 | Register read data |
| wait_i | input | 1 | WAIT strobe from the core |
| mask_evt_i | input | 1 | Maskable wake event (level) |
| nmi_i | input | 1 | Non-maskable interrupt (edge) |
| dbg_irq_i | input | 1 | Debug interrupt (edge) |
| intack_i | input | 1 | Interrupt-acknowledge cycle |
| clk_rdy_i | input | 1 | High-frequency clock stable |
| hf_clk_en_o | output | 1 | High-frequency clock enable |
| core_halt_o | output | 1 | Core halted (not Active) |
| mode_o | output | 2 | 00 Active, 01 Idle, 10 clock-restart |
| wake_o | output | 1 | Wake latch non-empty |
| wake_src_o | output | 3 | Latched wake sources |
| resume_o | output | 1 | One-cycle resume strobe |

## Verification
The hardest window to reach is the clock-restart state with the ready flag still low. The clock enable must have dropped first, so the bench drives `clk_rdy_i` from a model that follows `hf_clk_en_o` and raises the flag a programmable number of cycles after the clock returns. The bench then counts the cycles spent in clock-restart against that delay. The other tests cover two further corner cases. One latches a wake event in Active before the WAIT. The other holds a line high across an acknowledge, which separates the edge sources from the level source.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    PM_ACTIVE = 2'b00,
    PM_IDLE   = 2'b01,
    PM_WAKE   = 2'b10
  } pm_mode_e;

  localparam int CSR_W      = 4;
  localparam int BIT_IDLE   = 0;
  localparam int BIT_CLKOFF = 1;
  localparam int BIT_WAITEN = 2;
  localparam int BIT_RDY    = 3;

  localparam int N_LVL = 1;
  localparam int N_EDG = 2;
  localparam int SRC_W = N_LVL + N_EDG;
endpackage

// File: rtl/pmc_csr.sv
module pmc_csr
  import pmc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CSR_W-1:0] wdata_i,
  input  logic             hw_clr_idle_i,
  input  logic             hw_clr_clkoff_i,
  input  logic             clk_rdy_i,
  output logic             idle_req_o,
  output logic             clk_off_o,
  output logic             wait_en_o,
  output logic [CSR_W-1:0] rdata_o
);
  logic idle_q, clkoff_q, waiten_q;

  // hardware clears win over a same-cycle software write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q   <= 1'b0;
      clkoff_q <= 1'b0;
      waiten_q <= 1'b0;
    end else begin
      if (we_i) begin
        idle_q   <= wdata_i[BIT_IDLE];
        clkoff_q <= wdata_i[BIT_CLKOFF];
        waiten_q <= wdata_i[BIT_WAITEN];
      end
      if (hw_clr_idle_i)   idle_q   <= 1'b0;
      if (hw_clr_clkoff_i) clkoff_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o             = '0;
    rdata_o[BIT_IDLE]   = idle_q;
    rdata_o[BIT_CLKOFF] = clkoff_q;
    rdata_o[BIT_WAITEN] = waiten_q;
    rdata_o[BIT_RDY]    = clk_rdy_i;
  end

  assign idle_req_o = idle_q;
  assign clk_off_o  = clkoff_q;
  assign wait_en_o  = waiten_q;
endmodule

// File: rtl/pmc_wake_det.sv
module pmc_wake_det #(
  parameter int N_LVL = 1,
  parameter int N_EDG = 2,
  localparam int NS   = N_LVL + N_EDG
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_LVL-1:0] lvl_i,
  input  logic [N_EDG-1:0] edg_i,
  input  logic             ack_i,
  output logic [NS-1:0]    src_o,
  output logic             wake_o
);
  logic [N_EDG-1:0] edg_q;
  logic [NS-1:0]    hit, src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) edg_q <= '0;
    else         edg_q <= edg_i;
  end

  assign hit[N_LVL-1:0] = lvl_i;

  for (genvar g = 0; g < N_EDG; g++) begin : g_edge
    assign hit[N_LVL+g] = edg_i[g] & ~edg_q[g];
  end

  // ack empties the latch; a hit in the same cycle is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= '0;
    else         src_q <= (ack_i ? '0 : src_q) | hit;
  end

  assign src_o  = src_q;
  assign wake_o = |src_q;
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wait_i,
  input  logic     idle_req_i,
  input  logic     wait_en_i,
  input  logic     clk_off_i,
  input  logic     wake_i,
  input  logic     clk_rdy_i,
  output pm_mode_e mode_o,
  output logic     clr_clkoff_o,
  output logic     clr_idle_o,
  output logic     resume_o,
  output logic     hf_clk_en_o,
  output logic     halt_o
);
  pm_mode_e state_q, state_d;
  logic     resume_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PM_ACTIVE: if (wait_i && idle_req_i && wait_en_i) state_d = PM_IDLE;
      PM_IDLE:   if (wake_i)    state_d = PM_WAKE;
      PM_WAKE:   if (clk_rdy_i) state_d = PM_ACTIVE;
      default:   state_d = PM_ACTIVE;
    endcase
  end

  assign clr_clkoff_o = (state_q == PM_IDLE) && wake_i;
  assign clr_idle_o   = (state_q == PM_WAKE) && clk_rdy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= PM_ACTIVE;
      resume_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      resume_q <= clr_idle_o;
    end
  end

  assign mode_o      = state_q;
  assign resume_o    = resume_q;
  assign halt_o      = (state_q != PM_ACTIVE);
  assign hf_clk_en_o = !(clk_off_i && (state_q != PM_ACTIVE));
endmodule

// File: rtl/core_pwr_ctrl.sv
module core_pwr_ctrl
  import pmc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             csr_we_i,
  input  logic [CSR_W-1:0] csr_wdata_i,
  output logic [CSR_W-1:0] csr_rdata_o,
  input  logic             wait_i,
  input  logic             mask_evt_i,
  input  logic             nmi_i,
  input  logic             dbg_irq_i,
  input  logic             intack_i,
  input  logic             clk_rdy_i,
  output logic             hf_clk_en_o,
  output logic             core_halt_o,
  output logic [1:0]       mode_o,
  output logic             wake_o,
  output logic [SRC_W-1:0] wake_src_o,
  output logic             resume_o
);
  logic     idle_req, clk_off, wait_en, clr_idle, clr_clkoff;
  pm_mode_e mode;

  pmc_csr u_csr (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .we_i            (csr_we_i),
    .wdata_i         (csr_wdata_i),
    .hw_clr_idle_i   (clr_idle),
    .hw_clr_clkoff_i (clr_clkoff),
    .clk_rdy_i       (clk_rdy_i),
    .idle_req_o      (idle_req),
    .clk_off_o       (clk_off),
    .wait_en_o       (wait_en),
    .rdata_o         (csr_rdata_o)
  );

  pmc_wake_det #(.N_LVL(N_LVL), .N_EDG(N_EDG)) u_wake (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (mask_evt_i),
    .edg_i  ({dbg_irq_i, nmi_i}),
    .ack_i  (intack_i),
    .src_o  (wake_src_o),
    .wake_o (wake_o)
  );

  pmc_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wait_i       (wait_i),
    .idle_req_i   (idle_req),
    .wait_en_i    (wait_en),
    .clk_off_i    (clk_off),
    .wake_i       (wake_o),
    .clk_rdy_i    (clk_rdy_i),
    .mode_o       (mode),
    .clr_clkoff_o (clr_clkoff),
    .clr_idle_o   (clr_idle),
    .resume_o     (resume_o),
    .hf_clk_en_o  (hf_clk_en_o),
    .halt_o       (core_halt_o)
  );

  assign mode_o = mode;
endmodule

// File: rtl/core_pwr_ctrl_chk.sv
module core_pwr_ctrl_chk
  import pmc_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             csr_we_i,
  input logic [CSR_W-1:0] csr_rdata_o,
  input logic             wait_i,
  input logic             intack_i,
  input logic             clk_rdy_i,
  input logic             hf_clk_en_o,
  input logic [1:0]       mode_o,
  input logic             wake_o,
  input logic             resume_o
);
  localparam logic [1:0] M_ACT  = 2'b00;
  localparam logic [1:0] M_IDLE = 2'b01;
  localparam logic [1:0] M_WAKE = 2'b10;

  assert_reset_state_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (mode_o == M_ACT && !wake_o && !resume_o && csr_rdata_o[2:0] == 3'b000));

  assert_idle_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_ACT && wait_i && csr_rdata_o[BIT_IDLE] && csr_rdata_o[BIT_WAITEN])
    |=> mode_o == M_IDLE);

  assert_wait_blocked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_ACT && !(wait_i && csr_rdata_o[BIT_IDLE] && csr_rdata_o[BIT_WAITEN]))
    |=> mode_o == M_ACT);

  assert_clk_on_active_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_ACT) |-> hf_clk_en_o);

  assert_wake_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_o && !intack_i) |=> wake_o);

  assert_wake_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_IDLE && wake_o)
    |=> (mode_o == M_WAKE && !csr_rdata_o[BIT_CLKOFF] && hf_clk_en_o));

  assert_wake_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_WAKE && !clk_rdy_i) |=> mode_o == M_WAKE);

  assert_resume_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_WAKE && clk_rdy_i && !csr_we_i)
    |=> (mode_o == M_ACT && resume_o && !csr_rdata_o[BIT_IDLE]));

  assert_resume_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |=> !resume_o);
endmodule

bind core_pwr_ctrl core_pwr_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .csr_we_i    (csr_we_i),
  .csr_rdata_o (csr_rdata_o),
  .wait_i      (wait_i),
  .intack_i    (intack_i),
  .clk_rdy_i   (clk_rdy_i),
  .hf_clk_en_o (hf_clk_en_o),
  .mode_o      (mode_o),
  .wake_o      (wake_o),
  .resume_o    (resume_o)
);

// File: tb/sim_core_pwr_ctrl.sv
module sim_core_pwr_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       csr_we = 1'b0;
  logic [3:0] csr_wdata = '0;
  logic [3:0] csr_rdata;
  logic       wait_s = 1'b0, mask_evt = 1'b0, nmi = 1'b0, dbg = 1'b0, intack = 1'b0;
  logic       clk_rdy = 1'b0;
  logic       hf_en, halt, wake, resume;
  logic [1:0] mode;
  logic [2:0] wsrc;

  int checks = 0;
  int errors = 0;
  int rdy_dly = 4;
  int rdy_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  core_pwr_ctrl u0 (
    .clk_i (clk), .rst_ni (rst_n), .csr_we_i (csr_we), .csr_wdata_i (csr_wdata),
    .csr_rdata_o (csr_rdata), .wait_i (wait_s), .mask_evt_i (mask_evt), .nmi_i (nmi),
    .dbg_irq_i (dbg), .intack_i (intack), .clk_rdy_i (clk_rdy), .hf_clk_en_o (hf_en),
    .core_halt_o (halt), .mode_o (mode), .wake_o (wake), .wake_src_o (wsrc),
    .resume_o (resume)
  );

  // stable-clock detector model
  always @(negedge clk) begin
    if (!rst_n || !hf_en) begin
      rdy_cnt = 0;
      clk_rdy = 1'b0;
    end else if (rdy_cnt >= rdy_dly) clk_rdy = 1'b1;
    else rdy_cnt++;
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic csr_write(input logic [3:0] v);
    csr_we = 1'b1; csr_wdata = v;
    tick();
    csr_we = 1'b0;
  endtask

  task automatic enter_idle(input logic clkoff);
    csr_write({1'b0, 1'b1, clkoff, 1'b1});
    wait_s = 1'b1;
    tick();
    wait_s = 1'b0;
    chk("R3", "mode idle", int'(mode), 1);
    chk("R3", "halt", int'(halt), 1);
    chk("R5", "clk en in idle", int'(hf_en), int'(!clkoff));
  endtask

  // called one cycle after the wake latch was set while in Idle
  task automatic wake_seq(input logic clkoff);
    int n = 0;
    tick();
    chk("R8", "mode restart", int'(mode), 2);
    chk("R8", "clkoff cleared", int'(csr_rdata[1]), 0);
    chk("R8", "clk en", int'(hf_en), 1);
    while (!clk_rdy && n < 50) begin
      chk("R8", "hold restart", int'(mode), 2);
      tick();
      n++;
    end
    chk("R8", "restart cycles", n, clkoff ? rdy_dly : 0);
    tick();
    chk("R9", "mode active", int'(mode), 0);
    chk("R9", "resume", int'(resume), 1);
    chk("R9", "ctrl bits", int'(csr_rdata[2:0]), 3'b100);
    chk("R9", "halt", int'(halt), 0);
    tick();
    chk("R9", "resume pulse", int'(resume), 0);
  endtask

  task automatic ack();
    intack = 1'b1;
    tick();
    intack = 1'b0;
  endtask

  task automatic t_reset();
    tick();
    chk("R1", "mode in reset", int'(mode), 0);
    chk("R1", "wake in reset", int'(wake), 0);
    rst_n = 1'b1;
    tick();
    chk("R1", "mode", int'(mode), 0);
    chk("R1", "ctrl bits", int'(csr_rdata[2:0]), 0);
    chk("R1", "wake", int'(wake), 0);
    chk("R1", "resume", int'(resume), 0);
    chk("R1", "halt", int'(halt), 0);
    chk("R1", "clk en", int'(hf_en), 1);
  endtask

  task automatic t_csr();
    csr_write(4'b1111);
    chk("R2", "ctrl bits", int'(csr_rdata[2:0]), 3'b111);
    chk("R2", "ready mirror", int'(csr_rdata[3]), int'(clk_rdy));
    chk("R5", "clk en with clkoff in active", int'(hf_en), 1);
    csr_write(4'b1010);
    chk("R2", "ctrl bits", int'(csr_rdata[2:0]), 3'b010);
    chk("R2", "ready mirror", int'(csr_rdata[3]), int'(clk_rdy));
    csr_write(4'b0000);
    chk("R2", "cleared", int'(csr_rdata[2:0]), 0);
  endtask

  task automatic t_wait_blocked();
    csr_write(4'b0001);
    wait_s = 1'b1; tick(); wait_s = 1'b0;
    chk("R4", "no wait enable", int'(mode), 0);
    csr_write(4'b0100);
    wait_s = 1'b1; tick(); wait_s = 1'b0;
    chk("R4", "no idle request", int'(mode), 0);
    chk("R4", "halt", int'(halt), 0);
  endtask

  task automatic t_nmi_wake();
    rdy_dly = 4;
    enter_idle(1'b1);
    repeat (3) tick();
    chk("R3", "idle holds", int'(mode), 1);
    nmi = 1'b1;
    tick();
    nmi = 1'b0;
    chk("R6", "nmi source", int'(wsrc), 3'b010);
    chk("R8", "still idle", int'(mode), 1);
    wake_seq(1'b1);
    chk("R7", "sticky", int'(wake), 1);
    ack();
    chk("R7", "acked", int'(wake), 0);
  endtask

  task automatic t_dbg_wake();
    enter_idle(1'b0);
    dbg = 1'b1;
    tick();
    dbg = 1'b0;
    chk("R6", "dbg source", int'(wsrc), 3'b100);
    wake_seq(1'b0);
    ack();
    chk("R7", "acked", int'(wsrc), 0);
  endtask

  task automatic t_mask_wake();
    rdy_dly = 2;
    enter_idle(1'b1);
    mask_evt = 1'b1;
    tick();
    chk("R6", "mask source", int'(wsrc), 3'b001);
    wake_seq(1'b1);
    ack();
    chk("R6", "held level relatches", int'(wake), 1);
    mask_evt = 1'b0;
    ack();
    chk("R7", "acked", int'(wake), 0);
  endtask

  task automatic t_held_edge();
    nmi = 1'b1;
    tick();
    chk("R6", "nmi edge", int'(wsrc), 3'b010);
    ack();
    chk("R6", "held nmi not relatched", int'(wake), 0);
    tick();
    chk("R6", "held nmi stays clear", int'(wake), 0);
    nmi = 1'b0;
    tick();
  endtask

  task automatic t_active_wake();
    rdy_dly = 3;
    dbg = 1'b1;
    tick();
    dbg = 1'b0;
    chk("R10", "latched in active", int'(wake), 1);
    repeat (3) tick();
    chk("R10", "mode unchanged", int'(mode), 0);
    chk("R7", "still latched", int'(wake), 1);
    enter_idle(1'b1);
    wake_seq(1'b1);
    ack();
    chk("R7", "acked", int'(wake), 0);
  endtask

  initial begin
    t_reset();
    t_csr();
    t_wait_blocked();
    t_nmi_wake();
    t_dbg_wake();
    t_mask_wake();
    t_held_edge();
    t_active_wake();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule